// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames from a byte-wide stream and stores them in host memory through a ring of 16-byte receive descriptors. The block owns one descriptor at a time. It polls the status half-word of the current descriptor until the ownership bit says the device may fill it. It then loads the buffer pointer and the buffer size, which is stored as a negated 16-bit value. Incoming bytes go one at a time into that buffer. When the end-of-frame byte arrives, the block writes the byte count, including the 4-byte check sequence, into the descriptor's message-length word. It then writes the status half-word with the frame flags and the ownership bit cleared, which hands the entry back to the host.

The host supplies the ring base address and the base-2 logarithm of the ring size. The index wraps at that size. The stream has no backpressure. Any frame that begins while no owned descriptor is loaded is discarded whole and counted in a missed-frame counter. CRC, alignment and FIFO faults arrive as flags that go with the last byte. Buffer overrun is detected inside the block.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the missed-frame count is zero and the ring index is zero. The first memory access is a read of the word at ringBase + 4.
- R2: The block reads the word at ringBase + 16*index + 4 and accepts a frame only once bit 31 of that word (status bit 15, the ownership bit) was read as 1. It reads the buffer address from ringBase + 16*index + 0. While the ownership bit reads 0 it keeps polling.
- R3: Byte k of an accepted frame is written to buffer address + k. The write carries exactly one byte enable, lane = address[1:0] (little-endian lanes), and the byte is replicated on all four data lanes.
- R4: The buffer size is the two's-complement negation of bits 15:0 of the word at +4. Bytes at offsets at or beyond that size are not written, and the frame is reported with the overflow flag.
- R5: The word at +8 is written whole. Bits 11:0 hold the number of bytes received, including the check sequence and any truncated bytes, and bits 31:12 are zero.
- R6: The status is written into bits 31:16 of the word at +4 with byte enables 4'b1100 only, so the buffer-size half is kept. The status high byte is 0x03 (start and end of packet) OR'ed with 0x20 for a framing error, 0x10 for overflow, 0x08 for a CRC error and 0x04 for a FIFO error. The status low byte is 0 and status bit 15 is cleared.
- R7: The message-length write comes in the cycle just before the status write.
- R8: After the status write the index advances by one and wraps to 0 at 2^L, where L = ringLog2 (limited to MAX_LOG2). Entries beyond the ring are never touched.
- R9: A frame whose first byte arrives while no owned descriptor is loaded is dropped. None of its bytes are written, missCount rises by one, and the index does not move.
- R10: A frame that starts in the cycle right after the previous frame's last byte finds the descriptor write-back in progress, so it is dropped as in R9.
- R11: The error flags are sampled only with the end-of-frame byte. Values on earlier bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| rxValid | input | 1 | Stream byte valid |
| rxData | input | 8 | Stream byte |
| rxLast | input | 1 | Marks the last byte of a frame |
| rxCrcErr | input | 1 | CRC fault flag, valid with rxLast |
| rxFrameErr | input | 1 | Framing fault flag, valid with rxLast |
| rxFifoErr | input | 1 | FIFO fault flag, valid with rxLast |
| ringBase | input | ADDR_W | Byte address of descriptor 0, 16-byte aligned |
| ringLog2 | input | 4 | Base-2 logarithm of the ring size |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Write when 1, read when 0 |
| memBe | output | 4 | Byte enables for writes |
| memAddr | output | ADDR_W | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after a read |
| missCount | output | MISS_W | Dropped-frame counter, wraps |

## Verification
The hardest state to reach is a frame that begins while the previous descriptor is still being written back. It only occurs when a new first byte follows the previous end-of-frame byte with no gap. The bench sends two frames back to back and checks three things: the first frame lands, the second is counted as missed, and the next descriptor is still armed and untouched. Ring wrap for every size from 1 to 8 entries is swept with a fresh reset each time. A descriptor placed just past the ring is checked to show it stays unwritten. The frame-length sweep crosses the buffer boundary so that truncation and overflow reporting are exercised on both sides of it.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int DESC_SHIFT = 4;   // 16-byte descriptors
  localparam int OFF_STAT   = 4;   // buffer size [15:0], status [31:16]
  localparam int OFF_MLEN   = 8;   // message length word
  localparam int CNT_W      = 12;  // message length field width

  localparam logic [7:0] HI_GOOD  = 8'h03;
  localparam int         FLG_FRM  = 5;
  localparam int         FLG_OVF  = 4;
  localparam int         FLG_CRC  = 3;
  localparam int         FLG_FIFO = 2;

  typedef enum logic [2:0] {
    ST_POLL, ST_POLLW, ST_BASE, ST_BASEW, ST_READY, ST_RECV, ST_WLEN, ST_WSTAT
  } rxState_t;

  typedef struct packed {
    logic rdStat;
    logic capStat;
    logic rdBase;
    logic capBase;
    logic startFrame;
    logic wrByte;
    logic endFrame;
    logic wrLen;
    logic wrStat;
    logic advance;
    logic countMiss;
  } rxStrobe_t;

endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  logic      rxLast,
  input  logic      ownBit,
  output rxStrobe_t strobe
);

  rxState_t state, stateNext;
  logic     inFrame;
  logic     firstByte;

  assign firstByte = rxValid && !inFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_POLL;
      inFrame <= 1'b0;
    end else begin
      state <= stateNext;
      if (rxValid) inFrame <= !rxLast;
    end
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    strobe.countMiss = firstByte && (state != ST_READY);
    unique case (state)
      ST_POLL: begin
        strobe.rdStat = 1'b1;
        stateNext     = ST_POLLW;
      end
      ST_POLLW: begin
        strobe.capStat = 1'b1;
        stateNext      = ownBit ? ST_BASE : ST_POLL;
      end
      ST_BASE: begin
        strobe.rdBase = 1'b1;
        stateNext     = ST_BASEW;
      end
      ST_BASEW: begin
        strobe.capBase = 1'b1;
        stateNext      = ST_READY;
      end
      ST_READY: begin
        if (firstByte) begin
          strobe.startFrame = 1'b1;
          strobe.wrByte     = 1'b1;
          if (rxLast) begin
            strobe.endFrame = 1'b1;
            stateNext       = ST_WLEN;
          end else begin
            stateNext = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (rxValid) begin
          strobe.wrByte = 1'b1;
          if (rxLast) begin
            strobe.endFrame = 1'b1;
            stateNext       = ST_WLEN;
          end
        end
      end
      ST_WLEN: begin
        strobe.wrLen = 1'b1;
        stateNext    = ST_WSTAT;
      end
      ST_WSTAT: begin
        strobe.wrStat  = 1'b1;
        strobe.advance = 1'b1;
        stateNext      = ST_POLL;
      end
      default: stateNext = ST_POLL;
    endcase
  end

endmodule

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 9,
  parameter int MISS_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [7:0]        rxData,
  input  logic              rxCrcErr,
  input  logic              rxFrameErr,
  input  logic              rxFifoErr,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [3:0]        ringLog2,
  input  logic [31:0]       memRdata,
  output logic              ownBit,
  output logic              memEn,
  output logic              memWe,
  output logic [3:0]        memBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [MISS_W-1:0] missCount
);

  localparam int IDX_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  ringMask;
  logic [3:0]        effLog2;
  logic [ADDR_W-1:0] bufBase;
  logic [15:0]       bufLen;
  logic [CNT_W-1:0]  byteCnt;
  logic [CNT_W-1:0]  curOff;
  logic [CNT_W-1:0]  nextCnt;
  logic              ovf, errCrc, errFrm, errFifo;
  logic              inBuf;
  logic [ADDR_W-1:0] descAddr;
  logic [ADDR_W-1:0] byteAddr;
  logic [3:0]        laneBe;
  logic [7:0]        statHi;

  assign effLog2 = (32'(ringLog2) > MAX_LOG2) ? 4'(MAX_LOG2) : ringLog2;

  // ring wrap mask: one bit set per index bit inside the ring
  for (genvar i = 0; i < IDX_W; i++) begin : g_mask
    assign ringMask[i] = (i < 32'(effLog2));
  end

  // single-lane byte enable from the low address bits
  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign laneBe[l] = (byteAddr[1:0] == 2'(l));
  end

  assign ownBit   = memRdata[31];
  assign descAddr = ringBase + ADDR_W'({idx, {DESC_SHIFT{1'b0}}});
  assign curOff   = strobe.startFrame ? '0 : byteCnt;
  assign nextCnt  = (&curOff) ? curOff : curOff + 1'b1;
  assign inBuf    = {{(17 - CNT_W){1'b0}}, curOff} < {1'b0, bufLen};
  assign byteAddr = bufBase + ADDR_W'(curOff);

  always_comb begin
    statHi           = HI_GOOD;
    statHi[FLG_FRM]  = errFrm;
    statHi[FLG_OVF]  = ovf;
    statHi[FLG_CRC]  = errCrc;
    statHi[FLG_FIFO] = errFifo;
  end

  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memBe    = 4'b0000;
    memAddr  = descAddr;
    memWdata = '0;
    if (strobe.rdStat) begin
      memEn   = 1'b1;
      memAddr = descAddr + ADDR_W'(OFF_STAT);
    end else if (strobe.rdBase) begin
      memEn   = 1'b1;
      memAddr = descAddr;
    end else if (strobe.wrByte && inBuf) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memBe    = laneBe;
      memAddr  = {byteAddr[ADDR_W-1:2], 2'b00};
      memWdata = {4{rxData}};
    end else if (strobe.wrLen) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memBe    = 4'b1111;
      memAddr  = descAddr + ADDR_W'(OFF_MLEN);
      memWdata = 32'(byteCnt);
    end else if (strobe.wrStat) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memBe    = 4'b1100;
      memAddr  = descAddr + ADDR_W'(OFF_STAT);
      memWdata = {statHi, 8'h00, 16'h0000};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx       <= '0;
      bufBase   <= '0;
      bufLen    <= '0;
      byteCnt   <= '0;
      ovf       <= 1'b0;
      errCrc    <= 1'b0;
      errFrm    <= 1'b0;
      errFifo   <= 1'b0;
      missCount <= '0;
    end else begin
      if (strobe.capStat) bufLen  <= 16'(-memRdata[15:0]);
      if (strobe.capBase) bufBase <= ADDR_W'(memRdata);
      if (strobe.wrByte) begin
        byteCnt <= nextCnt;
        ovf     <= (strobe.startFrame ? 1'b0 : ovf) | !inBuf;
      end
      if (strobe.endFrame) begin
        errCrc  <= rxCrcErr;
        errFrm  <= rxFrameErr;
        errFifo <= rxFifoErr;
      end
      if (strobe.advance)   idx       <= (idx + 1'b1) & ringMask;
      if (strobe.countMiss) missCount <= missCount + 1'b1;
    end
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_LOG2 = 9,
  parameter int MISS_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              rxCrcErr,
  input  logic              rxFrameErr,
  input  logic              rxFifoErr,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [3:0]        ringLog2,
  output logic              memEn,
  output logic              memWe,
  output logic [3:0]        memBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic [MISS_W-1:0] missCount
);

  rxStrobe_t strobe;
  logic      ownBit;

  rxr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rxValid(rxValid),
    .rxLast (rxLast),
    .ownBit (ownBit),
    .strobe (strobe)
  );

  rxr_datapath #(
    .ADDR_W  (ADDR_W),
    .MAX_LOG2(MAX_LOG2),
    .MISS_W  (MISS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rxData    (rxData),
    .rxCrcErr  (rxCrcErr),
    .rxFrameErr(rxFrameErr),
    .rxFifoErr (rxFifoErr),
    .ringBase  (ringBase),
    .ringLog2  (ringLog2),
    .memRdata  (memRdata),
    .ownBit    (ownBit),
    .memEn     (memEn),
    .memWe     (memWe),
    .memBe     (memBe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .missCount (missCount)
  );

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic              memEn,
  input logic              memWe,
  input logic [3:0]        memBe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic [MISS_W-1:0] missCount
);

  logic isStatWr, isLenWr, isByteWr;
  assign isStatWr = memEn && memWe && (memBe == 4'b1100);
  assign isLenWr  = memEn && memWe && (memBe == 4'b1111);
  assign isByteWr = memEn && memWe && !isStatWr && !isLenWr;

  a_r7_len_before_stat: assert property (@(posedge clk) disable iff (!rstN)
    isStatWr |-> $past(isLenWr));

  a_r6_stat_owner_back: assert property (@(posedge clk) disable iff (!rstN)
    isStatWr |-> (!memWdata[31] && memWdata[25:24] == 2'b11 && memWdata[23:16] == 8'h00));

  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    isByteWr |-> ($countones(memBe) == 1 && rxValid && memAddr[1:0] == 2'b00));

  a_r5_len_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    isLenWr |-> (memWdata[31:12] == 20'h0));

  a_r9_miss_step: assert property (@(posedge clk) disable iff (!rstN)
    (missCount != $past(missCount)) |-> (missCount == $past(missCount) + 1'b1 && $past(rxValid)));

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rxValid  (rxValid),
  .memEn    (memEn),
  .memWe    (memWe),
  .memBe    (memBe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .missCount(missCount)
);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;

  localparam int BUF_SZ = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxLast = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        rxCrcErr = 1'b0, rxFrameErr = 1'b0, rxFifoErr = 1'b0;
  logic [31:0] ringBase = 32'h0;
  logic [3:0]  ringLog2 = 4'd2;
  logic        memEn, memWe;
  logic [3:0]  memBe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = 32'h0;
  logic [15:0] missCount;

  logic        hostWe = 1'b0;
  logic [31:0] hostAddr = 32'h0, hostData = 32'h0;
  logic [31:0] mem [512];

  int total = 0, bad = 0, frameNo = 0, expMiss = 0;
  bit done = 0;
  int lastLen [4];

  always #10 clk = ~clk;

  rx_ring_writer u_dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .rxCrcErr(rxCrcErr), .rxFrameErr(rxFrameErr), .rxFifoErr(rxFifoErr),
    .ringBase(ringBase), .ringLog2(ringLog2), .memEn(memEn), .memWe(memWe),
    .memBe(memBe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .missCount(missCount)
  );

  always @(posedge clk) begin
    if (hostWe) mem[hostAddr[10:2]] <= hostData;
    else if (memEn && memWe)
      for (int l = 0; l < 4; l++)
        if (memBe[l]) mem[memAddr[10:2]][8*l +: 8] <= memWdata[8*l +: 8];
    if (memEn && !memWe) memRdata <= mem[memAddr[10:2]];
  end

  function automatic logic [7:0] pat(int f, int k);
    return 8'(f * 13 + k * 7 + 1);
  endfunction

  function automatic logic [31:0] bufAddr(int i);
    return 32'h100 + 32'(i) * 32'h40;
  endfunction

  function automatic logic [7:0] rdByte(logic [31:0] a);
    return mem[a[10:2]][8*a[1:0] +: 8];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWr(logic [31:0] a, logic [31:0] d);
    hostWe = 1'b1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic armEntry(int i);
    for (int w = 0; w < 16; w++) hostWr(bufAddr(i) + 32'(4 * w), 32'hEEEEEEEE);
    hostWr(32'(16 * i), bufAddr(i));
    hostWr(32'(16 * i + 8), 32'hA5A55A5A);
    hostWr(32'(16 * i + 4), 32'h8000FFE0);  // owned, size -32
  endtask

  task automatic disarmEntry(int i);
    hostWr(32'(16 * i + 8), 32'h0);
    hostWr(32'(16 * i + 4), 32'h0000FFE0);
  endtask

  // flags: bit0 crc, bit1 framing, bit2 fifo; earlier bytes carry all flags set (R11)
  task automatic sendFrame(int len, logic [2:0] fl, int seed);
    for (int k = 0; k < len; k++) begin
      rxValid = 1'b1; rxData = pat(seed, k); rxLast = (k == len - 1);
      {rxFifoErr, rxFrameErr, rxCrcErr} = (k == len - 1) ? fl : 3'b111;
      @(negedge clk);
    end
    rxValid = 1'b0; rxLast = 1'b0;
    {rxFifoErr, rxFrameErr, rxCrcErr} = 3'b000;
  endtask

  task automatic checkEntry(int i, int len, logic [2:0] fl, int seed);
    int stored;
    bit okData, okRest;
    logic [7:0] expHi;
    stored = (len < BUF_SZ) ? len : BUF_SZ;
    okData = 1; okRest = 1;
    for (int k = 0; k < stored; k++)
      if (rdByte(bufAddr(i) + 32'(k)) !== pat(seed, k)) okData = 0;
    for (int k = stored; k < 64; k++)
      if (rdByte(bufAddr(i) + 32'(k)) !== 8'hEE) okRest = 0;
    expHi = 8'h03 | (fl[1] ? 8'h20 : 8'h0) | ((len > BUF_SZ) ? 8'h10 : 8'h0)
          | (fl[0] ? 8'h08 : 8'h0) | (fl[2] ? 8'h04 : 8'h0);
    check(okData, "R3 buffer bytes", 32'(okData), 32'd1);
    check(okRest, "R4 bytes past end untouched", 32'(okRest), 32'd1);
    check(mem[(16 * i + 8) / 4] === 32'(len), "R5 message length",
          mem[(16 * i + 8) / 4], 32'(len));
    check(mem[(16 * i + 4) / 4][31:16] === {expHi, 8'h00}, "R6 status half",
          32'(mem[(16 * i + 4) / 4][31:16]), {16'h0, expHi, 8'h00});
    check(mem[(16 * i + 4) / 4][15:0] === 16'hFFE0, "R6 size half kept",
          32'(mem[(16 * i + 4) / 4][15:0]), 32'hFFE0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 8; i++) disarmEntry(i);
    armEntry(0);
    rstN = 1'b1;
    #1;
    // R1: first access reads status word of entry 0
    check(memEn && !memWe && memAddr == 32'h4, "R1 first poll address", memAddr, 32'h4);
    check(missCount == 16'd0, "R1 missCount reset", 32'(missCount), 32'd0);
    @(negedge clk);

    // R2..R6, R11: length sweep across the buffer boundary, all flag combinations
    for (int n = 0; n < 40; n++) begin
      int e;
      e = n % 4;
      if (n != 0) armEntry(e);
      repeat (6) @(negedge clk);
      sendFrame(n + 1, 3'(n), frameNo);
      repeat (12) @(negedge clk);
      checkEntry(e, n + 1, 3'(n), frameNo);
      lastLen[e] = n + 1;
      frameNo++;
    end

    // R9: next entry (0) not owned -> frame dropped, index unchanged
    sendFrame(10, 3'b000, frameNo); frameNo++;
    expMiss++;
    repeat (12) @(negedge clk);
    check(missCount == 16'(expMiss), "R9 miss counted", 32'(missCount), 32'(expMiss));
    check(mem[2] === 32'(lastLen[0]), "R9 dropped frame wrote nothing",
          mem[2], 32'(lastLen[0]));
    armEntry(0);
    repeat (6) @(negedge clk);
    sendFrame(7, 3'b000, frameNo);
    repeat (12) @(negedge clk);
    checkEntry(0, 7, 3'b000, frameNo); frameNo++;

    // R10: back-to-back frame is dropped while write-back runs
    armEntry(1); armEntry(2);
    repeat (6) @(negedge clk);
    sendFrame(5, 3'b001, frameNo);
    sendFrame(6, 3'b000, frameNo + 1);
    expMiss++;
    repeat (12) @(negedge clk);
    checkEntry(1, 5, 3'b001, frameNo);
    check(missCount == 16'(expMiss), "R10 back-to-back miss", 32'(missCount), 32'(expMiss));
    check(mem[(16 * 2 + 4) / 4] === 32'h8000FFE0, "R10 next entry still armed",
          mem[(16 * 2 + 4) / 4], 32'h8000FFE0);
    frameNo += 2;
    sendFrame(9, 3'b100, frameNo);
    repeat (12) @(negedge clk);
    checkEntry(2, 9, 3'b100, frameNo); frameNo++;

    // R8: wrap sweep over ring sizes 1, 2, 4, 8
    for (int L = 0; L < 4; L++) begin
      int sz;
      sz = 1 << L;
      rstN = 1'b0;
      ringLog2 = 4'(L);
      for (int i = 0; i < 8; i++) disarmEntry(i);
      rstN = 1'b1;
      @(negedge clk);
      check(missCount == 16'd0, "R1 missCount after reset", 32'(missCount), 32'd0);
      for (int k = 0; k <= sz; k++) begin
        armEntry(k % sz);
        repeat (6) @(negedge clk);
        sendFrame(3 + k, 3'b000, frameNo);
        repeat (12) @(negedge clk);
        checkEntry(k % sz, 3 + k, 3'b000, frameNo);
        frameNo++;
      end
      if (L < 3)
        check(mem[(16 * sz + 8) / 4] === 32'h0, "R8 entry past ring untouched",
              mem[(16 * sz + 8) / 4], 32'h0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule